// File: doc/BRIEF.md
# Multi-Rate Write Data Path Aligner

This block sits on the controller side of a memory controller to PHY boundary. One PHY clock carries `SLOTS` memory-clock slots: 1 at full rate, 2 at half rate and 4 at quarter rate. The block takes a write command through a ready/valid handshake. Each command names the slot it was issued in and a burst length of one to four beats, one beat per memory-clock slot. It also carries the data and byte mask for every beat.

For each command the block schedules the burst on a timeline kept in memory-clock slots. It then drives four per-slot vectors: write-data-valid, write data, data mask and DQS-burst. The burst starts in the same slot index as its command and spills into the next PHY clock where needed. It is delayed by a write latency, counted in whole PHY clocks, that is captured when calibration completes. DQS-burst opens one or two memory clocks ahead of the first beat so the PHY can drive the preamble.

The handshake holds a command back in four cases: before calibration, during reset, when the burst would land on slots already taken, and, in CRC mode, when no idle slot would separate it from its neighbours.

Top module: `wdp_aligner`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every output vector is zero and `cmd_ready` is low.
- R2: `cmd_ready` stays low until `cal_done` has been seen high at a clock edge. It drops again one cycle after `cal_done` is seen low.
- R3: `wlat_in` is captured at the edge where `cal_done` is first seen high. Later changes to `wlat_in` have no effect on timing until calibration drops and rises again.
- R4: Let a command be accepted at clock edge E, in slot s, with captured latency W. Its beat b then appears in memory time (E+1+LEAD+W)*SLOTS+s+b, where LEAD = ceil(2/SLOTS). Output slot j after edge m stands for memory time m*SLOTS+j. The valid bit is high in exactly the slots holding beats.
- R5: `cmd_len` holds the number of beats minus one. Beat b takes its data from `cmd_data[8b+7:8b]` and its mask bit from `cmd_mask[b]`.
- R6: Commands in any slot 0..SLOTS-1 are accepted. A burst that runs past the last slot of a PHY clock continues in slot 0 of the next PHY clock without any gap.
- R7: DQS-burst is high from 1 memory clock before the first beat (`cfg_pre2`=0), or from 2 memory clocks before it (`cfg_pre2`=1), through the last beat. Overlapping or adjacent windows of different bursts merge into one.
- R8: `cmd_ready` is low when any beat of the offered burst would fall on a slot that already holds a scheduled beat.
- R9: With `cfg_crc` high, `cmd_ready` is also low when the slot just before the offered first beat, or just after its last beat, holds a scheduled beat.
- R10: A slot with valid low drives zero data and zero mask. This covers the idle slot that CRC mode keeps between bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_done | input | 1 | Calibration success from the PHY |
| wlat_in | input | WLAT_W | Write latency in PHY clocks |
| cfg_crc | input | 1 | CRC mode: keep an idle slot between bursts |
| cfg_pre2 | input | 1 | Two-clock write preamble |
| cmd_valid | input | 1 | Write command offered |
| cmd_ready | output | 1 | Write command accepted this cycle |
| cmd_slot | input | SLOT_W | Slot of the command within the PHY clock |
| cmd_len | input | LEN_W | Beats minus one |
| cmd_data | input | MAX_BEATS*8 | Data, beat b at bits 8b+7:8b |
| cmd_mask | input | MAX_BEATS | Mask, beat b at bit b |
| wr_valid | output | SLOTS | Per-slot write-data-valid |
| wr_data | output | SLOTS*8 | Per-slot write data |
| wr_mask | output | SLOTS | Per-slot data mask |
| wr_dqs | output | SLOTS | Per-slot DQS-burst |

## Verification
Two functions can fall on the same slot or in the same cycle. One is the DQS preamble of a new burst, which lands on the tail of an earlier burst. The other is the admission check, which must judge the new burst against slots already claimed while also weighing the CRC idle slot. A reference model in the bench keeps maps keyed by memory time. Fed a dense random stream of commands in every slot, with every length, it predicts `cmd_ready` and all four output vectors each cycle. The stream runs for every rate, latencies 0 to 3, both preamble settings and both CRC settings, so that merged windows and refused neighbours occur often.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

    localparam int WDP_DATA_W = 8;
    localparam int WDP_MASK_W = 1;

    typedef struct packed {
        logic                  valid;
        logic                  dqs;
        logic [WDP_MASK_W-1:0] mask;
        logic [WDP_DATA_W-1:0] data;
    } beat_t;

    // PHY clocks of lead needed so a two-slot preamble never precedes acceptance
    function automatic int lead_phy(input int slots);
        return (2 + slots - 1) / slots;
    endfunction

    function automatic int timeline_len(input int slots, input int max_wlat, input int max_beats);
        return (lead_phy(slots) + max_wlat + 1) * slots + max_beats + 1;
    endfunction

    function automatic int width_min1(input int v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction

endpackage

// File: rtl/wdp_cal_gate.sv
module wdp_cal_gate #(
    parameter int WLAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cal_done,
    input  logic [WLAT_W-1:0] wlat_in,
    output logic              cal_ok,
    output logic [WLAT_W-1:0] wlat_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_ok <= 1'b0;
            wlat_q <= '0;
        end else begin
            cal_ok <= cal_done;
            if (cal_done && !cal_ok) begin
                wlat_q <= wlat_in;
            end
        end
    end

    // R3: latency frozen while calibration holds
    p_wlat_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (cal_ok && cal_done) |=> $stable(wlat_q));

endmodule

// File: rtl/wdp_admit.sv
module wdp_admit #(
    parameter int SLOTS  = 2,
    parameter int TL_LEN = 16,
    parameter int WLAT_W = 2,
    parameter int LEN_W  = 2,
    parameter int SLOT_W = 1,
    parameter int IDX_W  = 5
) (
    input  logic [TL_LEN-1:0] busy,
    input  logic              cal_ok,
    input  logic              crc_en,
    input  logic [WLAT_W-1:0] wlat,
    input  logic [SLOT_W-1:0] slot,
    input  logic [LEN_W-1:0]  len,
    output logic [IDX_W-1:0]  base,
    output logic              ok
);
    import wdp_pkg::*;

    localparam int LEAD = lead_phy(SLOTS);

    int  base_i;
    int  last_i;
    logic hit;

    always_comb begin
        base_i = (LEAD + int'(wlat)) * SLOTS + ((SLOTS > 1) ? int'(slot) : 0);
        last_i = base_i + int'(len);
        hit    = 1'b0;
        for (int i = 0; i < TL_LEN; i++) begin
            if (busy[i]) begin
                if (i >= base_i && i <= last_i) hit = 1'b1;
                if (crc_en && (i + 1 == base_i || i == last_i + 1)) hit = 1'b1;
            end
        end
        ok   = cal_ok && !hit;
        base = IDX_W'(base_i);
    end

endmodule

// File: rtl/wdp_timeline.sv
module wdp_timeline #(
    parameter int SLOTS     = 2,
    parameter int TL_LEN    = 16,
    parameter int MAX_BEATS = 4,
    parameter int LEN_W     = 2,
    parameter int IDX_W     = 5
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  ins,
    input  logic [IDX_W-1:0]                      base,
    input  logic [LEN_W-1:0]                      len,
    input  logic                                  pre2,
    input  logic                                  crc_en,
    input  logic [MAX_BEATS*wdp_pkg::WDP_DATA_W-1:0] data,
    input  logic [MAX_BEATS*wdp_pkg::WDP_MASK_W-1:0] mask,
    output logic [TL_LEN-1:0]                     busy,
    output wdp_pkg::beat_t                        head [SLOTS]
);
    import wdp_pkg::*;

    localparam int DW = WDP_DATA_W;
    localparam int MW = WDP_MASK_W;

    beat_t tl [TL_LEN];
    beat_t sh [TL_LEN];
    beat_t nx [TL_LEN];

    // advance one PHY clock: SLOTS memory slots move toward the head
    for (genvar gi = 0; gi < TL_LEN; gi++) begin : g_shift
        if (gi + SLOTS < TL_LEN) begin : g_take
            assign sh[gi] = tl[gi+SLOTS];
        end else begin : g_fill
            assign sh[gi] = '0;
        end
        assign busy[gi] = sh[gi].valid;
    end

    for (genvar gj = 0; gj < SLOTS; gj++) begin : g_head
        assign head[gj] = tl[gj];
    end

    always_comb begin
        for (int i = 0; i < TL_LEN; i++) begin
            nx[i] = sh[i];
            for (int b = 0; b < MAX_BEATS; b++) begin
                if (ins && b <= int'(len)) begin
                    if (i == int'(base) + b) begin
                        nx[i].valid = 1'b1;
                        nx[i].dqs   = 1'b1;
                        nx[i].data  = data[b*DW +: DW];
                        nx[i].mask  = mask[b*MW +: MW];
                    end
                    if (i + 1 == int'(base) + b) nx[i].dqs = 1'b1;
                    if (pre2 && i + 2 == int'(base) + b) nx[i].dqs = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TL_LEN; i++) tl[i] <= '0;
        end else begin
            tl <= nx;
        end
    end

    // R8: an admitted burst never starts on a claimed slot
    p_free_slot_r8: assert property (@(posedge clk) disable iff (rst)
        ins |-> !busy[base]);

    // R9: in CRC mode the slot before an admitted burst is idle
    p_crc_gap_r9: assert property (@(posedge clk) disable iff (rst)
        (ins && crc_en) |-> !busy[base - IDX_W'(1)]);

endmodule

// File: rtl/wdp_aligner.sv
module wdp_aligner #(
    parameter int SLOTS     = 2,
    parameter int MAX_WLAT  = 3,
    parameter int MAX_BEATS = 4,
    localparam int WLAT_W   = wdp_pkg::width_min1(MAX_WLAT + 1),
    localparam int LEN_W    = wdp_pkg::width_min1(MAX_BEATS),
    localparam int SLOT_W   = wdp_pkg::width_min1(SLOTS),
    localparam int DW       = wdp_pkg::WDP_DATA_W,
    localparam int MW       = wdp_pkg::WDP_MASK_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cal_done,
    input  logic [WLAT_W-1:0]       wlat_in,
    input  logic                    cfg_crc,
    input  logic                    cfg_pre2,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [SLOT_W-1:0]       cmd_slot,
    input  logic [LEN_W-1:0]        cmd_len,
    input  logic [MAX_BEATS*DW-1:0] cmd_data,
    input  logic [MAX_BEATS*MW-1:0] cmd_mask,
    output logic [SLOTS-1:0]        wr_valid,
    output logic [SLOTS*DW-1:0]     wr_data,
    output logic [SLOTS*MW-1:0]     wr_mask,
    output logic [SLOTS-1:0]        wr_dqs
);
    import wdp_pkg::*;

    localparam int TL_LEN = timeline_len(SLOTS, MAX_WLAT, MAX_BEATS);
    localparam int IDX_W  = width_min1(TL_LEN + 1);

    logic              cal_ok;
    logic [WLAT_W-1:0] wlat_q;
    logic [TL_LEN-1:0] busy;
    logic [IDX_W-1:0]  base;
    logic              adm_ok;
    logic              ins;
    beat_t             head [SLOTS];

    wdp_cal_gate #(.WLAT_W(WLAT_W)) u_cal (
        .clk(clk), .rst(rst), .cal_done(cal_done), .wlat_in(wlat_in),
        .cal_ok(cal_ok), .wlat_q(wlat_q)
    );

    wdp_admit #(
        .SLOTS(SLOTS), .TL_LEN(TL_LEN), .WLAT_W(WLAT_W),
        .LEN_W(LEN_W), .SLOT_W(SLOT_W), .IDX_W(IDX_W)
    ) u_admit (
        .busy(busy), .cal_ok(cal_ok), .crc_en(cfg_crc), .wlat(wlat_q),
        .slot(cmd_slot), .len(cmd_len), .base(base), .ok(adm_ok)
    );

    assign cmd_ready = adm_ok & ~rst;
    assign ins       = cmd_valid & cmd_ready;

    wdp_timeline #(
        .SLOTS(SLOTS), .TL_LEN(TL_LEN), .MAX_BEATS(MAX_BEATS),
        .LEN_W(LEN_W), .IDX_W(IDX_W)
    ) u_tl (
        .clk(clk), .rst(rst), .ins(ins), .base(base), .len(cmd_len),
        .pre2(cfg_pre2), .crc_en(cfg_crc), .data(cmd_data), .mask(cmd_mask),
        .busy(busy), .head(head)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_valid <= '0;
            wr_data  <= '0;
            wr_mask  <= '0;
            wr_dqs   <= '0;
        end else begin
            for (int j = 0; j < SLOTS; j++) begin
                wr_valid[j]        <= head[j].valid;
                wr_dqs[j]          <= head[j].dqs;
                wr_data[j*DW +: DW] <= head[j].data;
                wr_mask[j*MW +: MW] <= head[j].mask;
            end
        end
    end

    // R2: no acceptance right after calibration is seen low
    p_hold_until_cal_r2: assert property (@(posedge clk) disable iff (rst)
        !cal_done |=> !cmd_ready);

    // R7: every data slot sits inside a DQS window
    p_dqs_covers_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_valid & ~wr_dqs) == '0);

    for (genvar gj = 0; gj < SLOTS; gj++) begin : g_chk
        // R10: idle slots carry nothing
        p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
            !wr_valid[gj] |-> (wr_data[gj*DW +: DW] == '0 && wr_mask[gj*MW +: MW] == '0));
        if (gj > 0) begin : g_pre
            // R7: preamble slot precedes a burst start inside the vector
            p_preamble_r7: assert property (@(posedge clk) disable iff (rst)
                (wr_valid[gj] && !wr_valid[gj-1]) |-> wr_dqs[gj-1]);
        end
    end

endmodule

// File: tb/wdp_aligner_run.sv
module wdp_aligner_run #(
    parameter int SLOTS = 2
) (
    input  logic clk,
    output logic done,
    output int   nchk,
    output int   nerr
);
    localparam int MB     = 4;
    localparam int LEAD   = (2 + SLOTS - 1) / SLOTS;
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic              rst, cal_done, cfg_crc, cfg_pre2, cmd_valid, cmd_ready;
    logic [1:0]        wlat_in;
    logic [SLOT_W-1:0] cmd_slot;
    logic [1:0]        cmd_len;
    logic [MB*8-1:0]   cmd_data;
    logic [MB-1:0]     cmd_mask;
    logic [SLOTS-1:0]  wr_valid, wr_mask, wr_dqs;
    logic [SLOTS*8-1:0] wr_data;

    wdp_aligner #(.SLOTS(SLOTS), .MAX_WLAT(3), .MAX_BEATS(MB)) u_wdp_aligner (
        .clk(clk), .rst(rst), .cal_done(cal_done), .wlat_in(wlat_in),
        .cfg_crc(cfg_crc), .cfg_pre2(cfg_pre2), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_slot(cmd_slot), .cmd_len(cmd_len),
        .cmd_data(cmd_data), .cmd_mask(cmd_mask), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_mask(wr_mask), .wr_dqs(wr_dqs)
    );

    // reference maps keyed by absolute memory-clock time
    bit         ev [int];
    bit         eq [int];
    logic [7:0] ed [int];
    bit         em [int];
    int         n;
    bit         mcal;
    int         mwlat;
    int unsigned seed;

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s slot-time %0d actual %0d expected %0d", req, n, act, exp);
        end
    endtask

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    function automatic bit model_ready();
        int first, last;
        if (rst || !mcal) return 1'b0;
        first = (n + 2 + LEAD + mwlat) * SLOTS + int'(cmd_slot);
        last  = first + int'(cmd_len);
        for (int t = first; t <= last; t++) if (ev.exists(t)) return 1'b0;   // R8
        if (cfg_crc && (ev.exists(first - 1) || ev.exists(last + 1))) return 1'b0; // R9
        return 1'b1;
    endfunction

    task automatic schedule();
        int first;
        first = (n + 2 + LEAD + mwlat) * SLOTS + int'(cmd_slot);
        for (int b = 0; b <= int'(cmd_len); b++) begin
            ev[first+b] = 1'b1;
            ed[first+b] = cmd_data[b*8 +: 8];
            em[first+b] = cmd_mask[b];
            eq[first+b] = 1'b1;
            eq[first+b-1] = 1'b1;
            if (cfg_pre2) eq[first+b-2] = 1'b1;
        end
    endtask

    task automatic tick();
        #1;
        if (n >= 1) begin
            for (int j = 0; j < SLOTS; j++) begin
                int t;
                t = n * SLOTS + j;
                check("R3 R4 R6 valid", int'(wr_valid[j]), int'(ev.exists(t)));
                check("R7 dqs", int'(wr_dqs[j]), int'(eq.exists(t)));
                check("R5 R10 data", int'(wr_data[j*8 +: 8]), ev.exists(t) ? int'(ed[t]) : 0);
                check("R5 R10 mask", int'(wr_mask[j]), ev.exists(t) ? int'(em[t]) : 0);
            end
        end
        if (!rst) check(mcal ? "R8 R9 ready" : "R2 ready", int'(cmd_ready), int'(model_ready()));
        if (!rst && cmd_valid && cmd_ready) schedule();
        @(posedge clk);
        n++;
        if (rst) begin
            mcal = 1'b0;
            ev.delete(); eq.delete(); ed.delete(); em.delete();
        end else begin
            if (cal_done && !mcal) mwlat = int'(wlat_in);
            mcal = cal_done;
        end
        @(negedge clk);
    endtask

    initial begin
        done = 1'b0; nchk = 0; nerr = 0; n = 0; mcal = 1'b0; mwlat = 0;
        seed = 32'h5eed + SLOTS;
        rst = 1'b1; cal_done = 1'b0; cfg_crc = 1'b0; cfg_pre2 = 1'b0;
        cmd_valid = 1'b0; cmd_slot = '0; cmd_len = '0; cmd_data = '0; cmd_mask = '0;
        wlat_in = '0;
        @(negedge clk);
        for (int w = 0; w < 4; w++) begin
            for (int p = 0; p < 2; p++) begin
                for (int c = 0; c < 2; c++) begin
                    rst = 1'b1; cal_done = 1'b0; cmd_valid = 1'b0;
                    cfg_crc = c[0]; cfg_pre2 = p[0]; wlat_in = w[1:0];
                    tick(); tick();
                    #1;
                    check("R1 reset valid", int'(wr_valid), 0);
                    check("R1 reset dqs", int'(wr_dqs), 0);
                    check("R1 reset ready", int'(cmd_ready), 0);
                    rst = 1'b0; cmd_valid = 1'b1; cmd_slot = '0; cmd_len = '0;
                    tick(); tick();
                    cal_done = 1'b1;
                    tick();
                    wlat_in = ~w[1:0];   // R3: must not move the schedule
                    for (int k = 0; k < 40; k++) begin
                        int unsigned r;
                        r = rnd();
                        cmd_valid = (r[1:0] != 2'd0);
                        cmd_slot  = SLOT_W'((r >> 2) % SLOTS);
                        cmd_len   = r[5:4];
                        for (int b = 0; b < MB; b++) cmd_data[b*8 +: 8] = 8'(rnd());
                        cmd_mask  = r[9:6];
                        tick();
                    end
                    cmd_valid = 1'b0;
                    repeat (LEAD + 10) tick();
                end
            end
        end
        done = 1'b1;
    end

endmodule

// File: tb/wdp_aligner_bench.sv
`timescale 1ns/1ps
module wdp_aligner_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic d1, d2, d4;
    int   c1, c2, c4, e1, e2, e4;
    int   wd_err;

    wdp_aligner_run #(.SLOTS(1)) u_run_full    (.clk(clk), .done(d1), .nchk(c1), .nerr(e1));
    wdp_aligner_run #(.SLOTS(2)) u_run_half    (.clk(clk), .done(d2), .nchk(c2), .nerr(e2));
    wdp_aligner_run #(.SLOTS(4)) u_run_quarter (.clk(clk), .done(d4), .nchk(c4), .nerr(e4));

    initial begin
        int cyc;
        wd_err = 0;
        cyc = 0;
        #1;
        while (!(d1 === 1'b1 && d2 === 1'b1 && d4 === 1'b1) && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (cyc >= 150000) begin
            wd_err = 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
        end
        #2;
        $display("CHECKS %0d ERRORS %0d", c1 + c2 + c4 + wd_err, e1 + e2 + e4 + wd_err);
        $finish;
    end
endmodule